// File: doc/BRIEF.md
# Parallel Sensor to AXI-Stream Bridge

This block sits directly behind the parallel pixel port of a CMOS image sensor and turns the raw pixel flow into an AXI4-Stream video stream in the same pixel clock domain. The sensor supplies a frame qualifier, a line qualifier and a 10-bit pixel split over two lanes: an 8-bit upper lane and a 2-bit lower lane. The bridge joins the two lanes into one word. It marks the first pixel of every frame on TUSER and the last pixel of every line on TLAST.

No frame buffer follows the bridge, so each line leaves as one unbroken burst, one beat per clock. Because a line's last pixel can only be recognised when the line qualifier drops, the bridge holds one pixel back. It releases that pixel with TLAST once the line ends. The sensor cannot be stalled. If the downstream stage refuses a beat, the beat is lost and a sticky overflow flag is raised. The pixel count of the most recently completed line is brought out so that line geometry can be checked, for example against an expected 1280-pixel line.

Top module: `pix2axis_bridge`

## Requirements
- R1: Each output word is `{upper lane, lower lane}`. The 8-bit upper lane occupies TDATA bits 9:2 and the 2-bit lower lane occupies bits 1:0.
- R2: A pixel is captured only on a clock edge where both the frame qualifier and the line qualifier are high. No beat is produced from any other cycle.
- R3: TUSER is high on the first beat after each rising edge of the frame qualifier and low on every other beat.
- R4: TLAST is high on the last captured pixel of every line. A line ends when the line qualifier falls or when the frame qualifier falls while the line qualifier is high.
- R5: Pixels leave in capture order, with TVALID high on consecutive clocks from a line's first beat to its TLAST beat.
- R6: `line_len` shows the number of pixels captured in the last completed line. It is updated on the clock that presents that line's TLAST beat and saturates at LINE_MAX.
- R7: A clock on which TVALID is high and TREADY is low sets `ovf_flag`, which stays high until reset. The beat is dropped and the following beats keep their one-per-clock timing.
- R8: A synchronous active-high reset clears TVALID, `ovf_flag`, `line_len`, the held pixel and any pending start-of-frame mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_act | input | 1 | Frame qualifier from the sensor |
| line_act | input | 1 | Line qualifier from the sensor |
| px_msb | input | MSB_W (8) | Upper pixel lane |
| px_lsb | input | LSB_W (2) | Lower pixel lane |
| m_tdata | output | PIX_W (10) | Stream data |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready from downstream |
| m_tuser | output | 1 | Start-of-frame mark |
| m_tlast | output | 1 | End-of-line mark |
| ovf_flag | output | 1 | Sticky overflow indicator |
| line_len | output | CW (12) | Pixel count of the last completed line |

## Verification
A stale or lost held pixel shows within one line as a wrong beat count, a misplaced word in the data sequence, or TLAST on the wrong beat. A start-of-frame mark that is not cleared after use appears as a second TUSER on the next beat. A mark that is never armed shows as a missing TUSER on the very next frame. A counter or qualifier fault reaches `line_len` on the clock of the TLAST beat, and a hole in TVALID is visible on the clock it happens.

// File: rtl/pix2axis_pkg.sv
package pix2axis_pkg;
   // sideband marks carried with a held pixel
   typedef struct packed {
      logic sof;
      logic eol;
   } beat_mark_t;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/px_in_stage.sv
module px_in_stage #(
   parameter int unsigned MSB_W     = 8,
   parameter int unsigned LSB_W     = 2,
   parameter int unsigned PIX_W     = MSB_W + LSB_W,
   parameter bit          INPUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fv_i,
   input  logic             lv_i,
   input  logic [MSB_W-1:0] msb_i,
   input  logic [LSB_W-1:0] lsb_i,
   output logic             fv_o,
   output logic             cap_o,
   output logic [PIX_W-1:0] pix_o
);
   logic [PIX_W-1:0] joined;
   assign joined = {msb_i, lsb_i};

   generate
      if (INPUT_REG) begin : g_reg
         logic             fv_r, lv_r;
         logic [PIX_W-1:0] pix_r;
         always_ff @(posedge clk) begin
            if (rst) begin
               fv_r  <= 1'b0;
               lv_r  <= 1'b0;
               pix_r <= '0;
            end else begin
               fv_r  <= fv_i;
               lv_r  <= lv_i;
               pix_r <= joined;
            end
         end
         assign fv_o  = fv_r;
         assign cap_o = fv_r & lv_r;
         assign pix_o = pix_r;
      end else begin : g_comb
         assign fv_o  = fv_i;
         assign cap_o = fv_i & lv_i;
         assign pix_o = joined;
      end
   endgenerate
endmodule

// File: rtl/px_sof_track.sv
module px_sof_track (
   input  logic clk,
   input  logic rst,
   input  logic fv_i,
   input  logic cap_i,
   output logic sof_o
);
   logic fv_q;
   logic armed;
   logic armed_now;

   assign armed_now = armed | (fv_i & ~fv_q);
   assign sof_o     = armed_now;

   always_ff @(posedge clk) begin
      if (rst) begin
         fv_q  <= 1'b0;
         armed <= 1'b0;
      end else begin
         fv_q  <= fv_i;
         armed <= cap_i ? 1'b0 : armed_now;
      end
   end
endmodule

// File: rtl/px_hold_emit.sv
module px_hold_emit
   import pix2axis_pkg::*;
#(
   parameter int unsigned PIX_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cap_i,
   input  logic [PIX_W-1:0] pix_i,
   input  logic             sof_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             vld_o,
   output logic [PIX_W-1:0] data_o,
   output logic             user_o,
   output logic             last_o
);
   logic             held;
   logic [PIX_W-1:0] held_pix;
   beat_mark_t       held_mark;
   beat_mark_t       out_mark;

   assign busy_o = held;
   assign done_o = held & ~cap_i;
   assign user_o = out_mark.sof;
   assign last_o = out_mark.eol;

   always_ff @(posedge clk) begin
      if (rst) begin
         held      <= 1'b0;
         held_pix  <= '0;
         held_mark <= '0;
         vld_o     <= 1'b0;
         data_o    <= '0;
         out_mark  <= '0;
      end else begin
         vld_o    <= 1'b0;
         out_mark <= '0;
         if (cap_i) begin
            if (held) begin
               vld_o        <= 1'b1;
               data_o       <= held_pix;
               out_mark.sof <= held_mark.sof;
            end
            held          <= 1'b1;
            held_pix      <= pix_i;
            held_mark.sof <= sof_i;
            held_mark.eol <= 1'b0;
         end else if (held) begin
            vld_o        <= 1'b1;
            data_o       <= held_pix;
            out_mark.sof <= held_mark.sof;
            out_mark.eol <= 1'b1;
            held         <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/px_line_count.sv
module px_line_count #(
   parameter int unsigned LINE_MAX = 4095,
   parameter int unsigned CW       = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cap_i,
   input  logic          busy_i,
   input  logic          done_i,
   output logic [CW-1:0] len_o
);
   localparam logic [CW-1:0] SAT = CW'(LINE_MAX);
   logic [CW-1:0] run;

   always_ff @(posedge clk) begin
      if (rst) begin
         run   <= '0;
         len_o <= '0;
      end else begin
         if (cap_i) begin
            if (!busy_i)
               run <= CW'(1);
            else if (run != SAT)
               run <= run + CW'(1);
         end
         if (done_i)
            len_o <= run;
      end
   end
endmodule

// File: rtl/pix2axis_bridge.sv
module pix2axis_bridge
   import pix2axis_pkg::*;
#(
   parameter int unsigned MSB_W     = 8,
   parameter int unsigned LSB_W     = 2,
   parameter int unsigned LINE_MAX  = 4095,
   parameter bit          INPUT_REG = 1'b0,
   localparam int unsigned PIX_W    = MSB_W + LSB_W,
   localparam int unsigned CW       = cnt_width(LINE_MAX)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             frame_act,
   input  logic             line_act,
   input  logic [MSB_W-1:0] px_msb,
   input  logic [LSB_W-1:0] px_lsb,
   output logic [PIX_W-1:0] m_tdata,
   output logic             m_tvalid,
   input  logic             m_tready,
   output logic             m_tuser,
   output logic             m_tlast,
   output logic             ovf_flag,
   output logic [CW-1:0]    line_len
);
   generate
      if (MSB_W < 1 || LSB_W < 1) begin : g_bad_lane
         $error("pix2axis_bridge: both pixel lanes need at least one bit");
      end
      if (LINE_MAX < 1) begin : g_bad_max
         $error("pix2axis_bridge: LINE_MAX must be at least 1");
      end
   endgenerate

   logic             fv_s, cap_s, sof_s, busy_s, done_s;
   logic [PIX_W-1:0] pix_s;

   px_in_stage #(
      .MSB_W(MSB_W), .LSB_W(LSB_W), .PIX_W(PIX_W), .INPUT_REG(INPUT_REG)
   ) u_in (
      .clk(clk), .rst(rst), .fv_i(frame_act), .lv_i(line_act),
      .msb_i(px_msb), .lsb_i(px_lsb),
      .fv_o(fv_s), .cap_o(cap_s), .pix_o(pix_s)
   );

   px_sof_track u_sof (
      .clk(clk), .rst(rst), .fv_i(fv_s), .cap_i(cap_s), .sof_o(sof_s)
   );

   px_hold_emit #(.PIX_W(PIX_W)) u_hold (
      .clk(clk), .rst(rst), .cap_i(cap_s), .pix_i(pix_s), .sof_i(sof_s),
      .busy_o(busy_s), .done_o(done_s),
      .vld_o(m_tvalid), .data_o(m_tdata), .user_o(m_tuser), .last_o(m_tlast)
   );

   px_line_count #(.LINE_MAX(LINE_MAX), .CW(CW)) u_cnt (
      .clk(clk), .rst(rst), .cap_i(cap_s), .busy_i(busy_s),
      .done_i(done_s), .len_o(line_len)
   );

   // refused beats are lost; the flag remembers it
   always_ff @(posedge clk) begin
      if (rst)
         ovf_flag <= 1'b0;
      else if (m_tvalid && !m_tready)
         ovf_flag <= 1'b1;
   end
endmodule

// File: rtl/pix2axis_bridge_chk.sv
module pix2axis_bridge_chk (
   input logic clk,
   input logic rst,
   input logic m_tvalid,
   input logic m_tready,
   input logic m_tuser,
   input logic m_tlast,
   input logic ovf_flag
);
   // R3
   user_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
      m_tuser |-> m_tvalid);

   // R4
   last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
      m_tlast |-> m_tvalid);

   // R5
   burst_unbroken_chk: assert property (@(posedge clk) disable iff (rst)
      (m_tvalid && !m_tlast) |=> m_tvalid);

   // R7
   refused_sets_ovf_chk: assert property (@(posedge clk) disable iff (rst)
      (m_tvalid && !m_tready) |=> ovf_flag);

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      ovf_flag |=> ovf_flag);
endmodule

bind pix2axis_bridge pix2axis_bridge_chk u_chk (
   .clk(clk), .rst(rst), .m_tvalid(m_tvalid), .m_tready(m_tready),
   .m_tuser(m_tuser), .m_tlast(m_tlast), .ovf_flag(ovf_flag)
);

// File: tb/pix2axis_bridge_bench.sv
module pix2axis_bridge_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fa = 1'b0, la = 1'b0, rdy = 1'b1;
   logic [7:0]  pm = '0;
   logic [1:0]  pl = '0;
   logic [9:0]  td;
   logic        tv, tu, tl, ovf;
   logic [11:0] llen;

   int pass_n = 0, fail_n = 0, cyc = 0, nb = 0;
   logic [9:0] b_data [0:4095];
   logic       b_user [0:4095];
   logic       b_last [0:4095];
   int         b_cyc  [0:4095];

   pix2axis_bridge u_pix2axis_bridge (
      .clk(clk), .rst(rst), .frame_act(fa), .line_act(la),
      .px_msb(pm), .px_lsb(pl), .m_tdata(td), .m_tvalid(tv),
      .m_tready(rdy), .m_tuser(tu), .m_tlast(tl), .ovf_flag(ovf),
      .line_len(llen)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) begin
      if (tv && nb < 4096) begin
         b_data[nb] = td; b_user[nb] = tu; b_last[nb] = tl; b_cyc[nb] = cyc;
         nb = nb + 1;
      end
   end

   function automatic logic [9:0] pv(input int seed, input int ln, input int ix);
      return 10'((seed * 97 + ln * 37 + ix * 5 + 3) & 1023);
   endfunction

   task automatic chk(input bit ok, input string req, input int got, input int exp);
      if (ok) pass_n++;
      else begin
         fail_n++;
         $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic put_pix(input logic [9:0] v);
      pm = v[9:2]; pl = v[1:0];
   endtask

   // drive one frame of nl lines of len pixels, gap idle clocks between lines
   task automatic drive_frame(input int seed, input int nl, input int len, input int gap);
      @(negedge clk); fa = 1'b1;
      idle(2);
      for (int l = 0; l < nl; l++) begin
         for (int i = 0; i < len; i++) begin
            la = 1'b1; put_pix(pv(seed, l, i));
            @(negedge clk);
         end
         la = 1'b0; put_pix(10'h2aa);
         idle(gap);
      end
      fa = 1'b0;
      idle(4);
   endtask

   task automatic verify(input int seed, input int nl, input int len, input string tag);
      int bad_d = 0, bad_u = 0, bad_l = 0, bad_c = 0;
      chk(nb == nl * len, {tag, " R2 beat count"}, nb, nl * len);
      for (int j = 0; j < nb && j < nl * len; j++) begin
         int ln = j / len;
         int ix = j % len;
         if (b_data[j] != pv(seed, ln, ix)) bad_d++;
         if (b_user[j] != (j == 0)) bad_u++;
         if (b_last[j] != (ix == len - 1)) bad_l++;
         if (ix > 0 && b_cyc[j] != b_cyc[j-1] + 1) bad_c++;
      end
      chk(bad_d == 0, {tag, " R1 data order/packing mismatches"}, bad_d, 0);
      chk(bad_u == 0, {tag, " R3 tuser placement mismatches"}, bad_u, 0);
      chk(bad_l == 0, {tag, " R4 tlast placement mismatches"}, bad_l, 0);
      chk(bad_c == 0, {tag, " R5 tvalid gaps inside a line"}, bad_c, 0);
      chk(int'(llen) == len, {tag, " R6 line_len"}, int'(llen), len);
   endtask

   task automatic t_reset();
      rst = 1'b1; idle(3);
      chk(tv == 1'b0, "R8 tvalid in reset", int'(tv), 0);
      chk(ovf == 1'b0, "R8 ovf in reset", int'(ovf), 0);
      chk(llen == '0, "R8 line_len in reset", int'(llen), 0);
      rst = 1'b0; idle(2);
   endtask

   task automatic t_full_frame();
      nb = 0;
      drive_frame(1, 3, 1280, 6);
      verify(1, 3, 1280, "full");
      chk(ovf == 1'b0, "R7 no overflow when ready", int'(ovf), 0);
   endtask

   task automatic t_short_frame();
      nb = 0;
      drive_frame(2, 4, 7, 1);
      verify(2, 4, 7, "short");
   endtask

   task automatic t_qualify();
      nb = 0;
      @(negedge clk); fa = 1'b0;
      for (int i = 0; i < 10; i++) begin la = 1'b1; put_pix(10'(i)); @(negedge clk); end
      la = 1'b0;
      fa = 1'b1; idle(10); fa = 1'b0; idle(4);
      chk(nb == 0, "R2 no beats without both qualifiers", nb, 0);
      chk(int'(llen) == 7, "R2 line_len untouched by unqualified pixels", int'(llen), 7);
   endtask

   task automatic t_single();
      nb = 0;
      drive_frame(3, 1, 1, 2);
      chk(nb == 1, "R4 single-pixel line beat count", nb, 1);
      chk(b_user[0] == 1'b1 && b_last[0] == 1'b1, "R4 single pixel carries tuser and tlast",
          int'({b_user[0], b_last[0]}), 3);
      chk(int'(llen) == 1, "R6 line_len single pixel", int'(llen), 1);
   endtask

   task automatic t_frame_cut();
      nb = 0;
      @(negedge clk); fa = 1'b1; idle(2);
      for (int i = 0; i < 4; i++) begin la = 1'b1; put_pix(pv(4, 0, i)); @(negedge clk); end
      fa = 1'b0;
      idle(3); la = 1'b0; idle(4);
      chk(nb == 4, "R4 frame cut beat count", nb, 4);
      chk(nb == 4 && b_last[3] == 1'b1 && b_last[2] == 1'b0, "R4 tlast on frame cut",
          int'(b_last[3]), 1);
      chk(int'(llen) == 4, "R6 line_len on frame cut", int'(llen), 4);
   endtask

   task automatic t_overflow();
      nb = 0;
      rdy = 1'b0;
      drive_frame(5, 1, 5, 2);
      chk(nb == 5, "R7 beats keep flowing while refused", nb, 5);
      chk(nb == 5 && b_cyc[4] == b_cyc[0] + 4, "R7 no stall while refused",
          b_cyc[4] - b_cyc[0], 4);
      chk(ovf == 1'b1, "R7 overflow set", int'(ovf), 1);
      rdy = 1'b1;
      nb = 0;
      drive_frame(6, 2, 3, 2);
      verify(6, 2, 3, "after-ovf");
      chk(ovf == 1'b1, "R7 overflow sticky", int'(ovf), 1);
      @(negedge clk); rst = 1'b1; idle(2); rst = 1'b0; idle(1);
      chk(ovf == 1'b0 && llen == '0, "R8 reset clears overflow and line_len",
          int'(ovf), 0);
   endtask

   initial begin
      idle(1);
      t_reset();
      t_full_frame();
      t_short_frame();
      t_qualify();
      t_single();
      t_frame_cut();
      t_overflow();
      $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fail_n++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
      $finish;
   end
endmodule